// File: doc/BRIEF.md
# PROM Readback Verification Scanner

This block runs the readback checks of a one-time-programmable memory. It steps through every word, drives the memory's address, active-low chip select and active-low output enable, and compares the returned word with an expected value. It keeps the program strobe inactive at all times and selects the supply level the external regulator should apply. The expected word comes from an outside port that follows the address the scanner drives. It is read in the same cycle as the memory data.

Three kinds of scan are offered. A blank check expects every bit of every word to read zero. A verify pass compares each word with its expected value at the nominal supply. A margin pass sweeps the whole array at the low supply level and then repeats the sweep at the high level. On the first mismatch the scanner records the failing address and the supply level, flags the device as rejected and stops. It gives a one-cycle completion pulse whether the scan passed or was cut short.

Top module: `prom_scan`

## Requirements
- R1: After reset, and whenever no scan is running, `busy`, `done` and `reject` are 0, `sel_n` and `oe_n` are 1, `prog_n` is 1 and `supply_sel` is 0.
- R2: A scan starts when `start` is 1 in an idle cycle and `mode` is 0 (blank), 1 (verify) or 2 (margin). Mode 3 starts nothing. A `start` seen while a scan runs has no effect.
- R3: In blank mode every word is compared against all zeros and `ref_q` is ignored. Any bit that reads 1 rejects the device.
- R4: In verify mode `supply_sel` is 0 (nominal). For each word the address is held with `sel_n` high for T_D cycles, then `sel_n` is low for T_D cycles, and the data is compared in the last low cycle. Blank mode uses the same timing. `prog_n` stays 1 throughout, and `oe_n` is 0 for the whole scan.
- R5: In margin mode the full array is swept with `supply_sel` = 1 (low), then again with `supply_sel` = 2 (high). For each word `sel_n` is high for T_D + T_AVEL cycles with the address applied, then low for T_ELQV cycles, with the compare in the last low cycle.
- R6: After each supply level is selected, there is a settle wait of T_D cycles before the first word's access phase begins. A passing scan lasts T_D + DEPTH·2·T_D + 1 busy cycles in blank or verify mode, and 2·(T_D + DEPTH·(T_D+T_AVEL+T_ELQV)) + 1 busy cycles in margin mode.
- R7: On a mismatch `reject` goes to 1, `fail_addr` holds the failing word's address and `fail_level` holds the supply code then in use. The scan ends without accessing any further word. These outputs hold until the next accepted start.
- R8: `done` is high for exactly one cycle at the end of every accepted scan. After a passing scan `reject` is 0.
- R9: The address and the supply code do not change while `sel_n` is low. The address counter wraps from DEPTH-1 to 0, so the high-level margin sweep begins at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a scan in the mode given by `mode` |
| mode | input | 2 | 0 blank, 1 verify, 2 margin, 3 reserved |
| ref_q | input | DW | Expected word for the current `dev_addr` |
| dev_q | input | DW | Data read back from the memory |
| dev_addr | output | AW | Word address driven to the memory and the expected-data port |
| sel_n | output | 1 | Active-low chip select |
| oe_n | output | 1 | Active-low output enable |
| prog_n | output | 1 | Active-low program strobe, held inactive |
| supply_sel | output | 2 | Supply level request: 0 nominal, 1 low, 2 high |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| reject | output | 1 | Device failed the last scan |
| fail_addr | output | AW | Address of the first mismatch |
| fail_level | output | 2 | Supply code in use at the first mismatch |

## Verification
The memory model answers per supply level. Faults can therefore be placed at one level only, which separates the low sweep from the high sweep and shows that the nominal contents are ignored in margin mode. A blank pass is run with a non-zero expected pattern, showing that `ref_q` is not used there. Single-bit faults at the first, a middle and the last address show that the compare position and the early stop are correct. Measuring select pulse widths, the gaps between them, the gap across the level change and the total busy time checks the enable timing of each mode. This also catches an off-by-one in any wait. Reserved-mode and mid-scan start requests confirm that they are rejected.

// File: rtl/prom_scan_pkg.sv
// Shared types for the PROM readback scanner.
// Assumes: mode and supply encodings are fixed by the block's port contract.
package prom_scan_pkg;

    typedef enum logic [1:0] {
        MODE_BLANK  = 2'd0,
        MODE_VERIFY = 2'd1,
        MODE_MARGIN = 2'd2,
        MODE_RSVD   = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        LVL_NOM  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } supply_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_PRE,
        S_ADDR,
        S_ENAB,
        S_FIN
    } state_e;

endpackage

// File: rtl/prom_scan_timer.sv
// Down-counting phase timer.
// Does: loads a count on a phase change and counts down to zero.
// Assumes: a phase of N cycles is loaded with N-1, so zero marks its last cycle.
module prom_scan_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/prom_scan_addr.sv
// Word address counter.
// Does: clears on request, steps by one and wraps from DEPTH-1 to 0.
// Assumes: DEPTH >= 2.
module prom_scan_addr #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);

    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;

    // Clear, or step with wrap at the depth limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr_q <= '0;
        end else if (inc) begin
            addr_q <= (addr_q == TOP) ? '0 : addr_q + AW'(1);
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == TOP);

endmodule

// File: rtl/prom_scan_cmp.sv
// Readback comparator.
// Does: compares the read word with the expected word, or with zero in blank mode.
// Assumes: both inputs are valid in the cycle the result is used.
module prom_scan_cmp #(
    parameter int DW = 8
) (
    input  logic          blank,
    input  logic [DW-1:0] rd_word,
    input  logic [DW-1:0] ref_word,
    output logic          mismatch
);

    logic [DW-1:0] diff;

    // One difference bit per data line.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign diff[b] = rd_word[b] ^ (blank ? 1'b0 : ref_word[b]);
    end

    assign mismatch = |diff;

endmodule

// File: rtl/prom_scan.sv
// PROM readback verification scanner (top).
// Does: sweeps all words in blank, verify or two-level margin mode, sequencing
//       address, chip select and output enable, and stops at the first mismatch.
// Assumes: T_D, T_AVEL and T_ELQV are >= 1 cycle; ref_q follows dev_addr
//          combinationally; the supply settles within T_D cycles of a code change.
module prom_scan #(
    parameter int DEPTH  = 16,
    parameter int DW     = 8,
    parameter int T_D    = 3,
    parameter int T_AVEL = 2,
    parameter int T_ELQV = 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] ref_q,
    input  logic [DW-1:0] dev_q,
    output logic [AW-1:0] dev_addr,
    output logic          sel_n,
    output logic          oe_n,
    output logic          prog_n,
    output logic [1:0]    supply_sel,
    output logic          busy,
    output logic          done,
    output logic          reject,
    output logic [AW-1:0] fail_addr,
    output logic [1:0]    fail_level
);

    import prom_scan_pkg::*;

    localparam int WMAX = (T_D > T_AVEL) ? ((T_D > T_ELQV) ? T_D : T_ELQV)
                                         : ((T_AVEL > T_ELQV) ? T_AVEL : T_ELQV);
    localparam int TW   = (WMAX < 2) ? 1 : $clog2(WMAX);

    state_e     state_q, state_d;
    scan_mode_e mode_q;
    supply_e    level_q;
    logic       reject_q;
    logic [AW-1:0] fail_addr_q;
    supply_e    fail_level_q;

    logic          tmr_zero, tmr_load;
    logic [TW-1:0] tmr_val;
    logic          addr_clr, addr_inc, addr_last;
    logic          mismatch, fire, fail, accept, margin;

    assign margin = (mode_q == MODE_MARGIN);
    assign accept = (state_q == S_IDLE) && start && (scan_mode_e'(mode) != MODE_RSVD);
    assign fire   = (state_q == S_ENAB) && tmr_zero;
    assign fail   = fire && mismatch;

    // Phase length in cycles for a given state in the latched mode.
    function automatic int phase_len(input state_e s, input logic mg);
        case (s)
            S_SETTLE: phase_len = T_D;
            S_PRE:    phase_len = T_D;
            S_ADDR:   phase_len = mg ? T_AVEL : T_D;
            S_ENAB:   phase_len = mg ? T_ELQV : T_D;
            default:  phase_len = 1;
        endcase
    endfunction

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:   if (accept) state_d = S_SETTLE;
            S_SETTLE: if (tmr_zero) state_d = margin ? S_PRE : S_ADDR;
            S_PRE:    if (tmr_zero) state_d = S_ADDR;
            S_ADDR:   if (tmr_zero) state_d = S_ENAB;
            S_ENAB: begin
                if (tmr_zero) begin
                    if (mismatch)
                        state_d = S_FIN;
                    else if (addr_last)
                        state_d = (margin && level_q == LVL_LOW) ? S_SETTLE : S_FIN;
                    else
                        state_d = margin ? S_PRE : S_ADDR;
                end
            end
            S_FIN:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Timer reload on every phase change.
    assign tmr_load = (state_d != state_q);
    assign tmr_val  = TW'(phase_len(state_d, margin) - 1);

    // Address steps after each passing compare and wraps at the end of a sweep.
    assign addr_clr = accept;
    assign addr_inc = fire && !mismatch;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Mode latch and supply level sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_BLANK;
            level_q <= LVL_NOM;
        end else if (accept) begin
            mode_q  <= scan_mode_e'(mode);
            level_q <= (scan_mode_e'(mode) == MODE_MARGIN) ? LVL_LOW : LVL_NOM;
        end else if (fire && !mismatch && addr_last && margin && level_q == LVL_LOW) begin
            level_q <= LVL_HIGH;
        end else if (state_q == S_FIN) begin
            level_q <= LVL_NOM;
        end
    end

    // Reject flag and first-failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            reject_q     <= 1'b0;
            fail_addr_q  <= '0;
            fail_level_q <= LVL_NOM;
        end else if (fail) begin
            reject_q     <= 1'b1;
            fail_addr_q  <= dev_addr;
            fail_level_q <= level_q;
        end
    end

    prom_scan_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    prom_scan_addr #(.DEPTH(DEPTH)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .inc   (addr_inc),
        .addr  (dev_addr),
        .last  (addr_last)
    );

    prom_scan_cmp #(.DW(DW)) u_cmp (
        .blank    (mode_q == MODE_BLANK),
        .rd_word  (dev_q),
        .ref_word (ref_q),
        .mismatch (mismatch)
    );

    assign sel_n      = (state_q != S_ENAB);
    assign oe_n       = (state_q == S_IDLE);
    assign prog_n     = 1'b1;
    assign supply_sel = level_q;
    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_FIN);
    assign reject     = reject_q;
    assign fail_addr  = fail_addr_q;
    assign fail_level = fail_level_q;

endmodule

// File: rtl/prom_scan_chk.sv
// Protocol checker for the PROM readback scanner.
// Does: watches the memory-side strobes and the scan status over time.
// Assumes: bound into every prom_scan instance.
module prom_scan_chk #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] dev_addr,
    input logic          sel_n,
    input logic          oe_n,
    input logic          prog_n,
    input logic [1:0]    supply_sel,
    input logic          busy,
    input logic          done,
    input logic          reject
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sel_n && oe_n && !done))
        else $error("idle strobes active");

    p_prog_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> prog_n)
        else $error("program strobe active during scan");

    p_sel_needs_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> !oe_n)
        else $error("select without output enable");

    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && $past(!sel_n)) |-> $stable(supply_sel))
        else $error("supply changed during access");

    p_reject_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reject) |-> done)
        else $error("reject without scan end");

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && $past(!sel_n)) |-> $stable(dev_addr))
        else $error("address changed during access");

endmodule

bind prom_scan prom_scan_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_addr   (dev_addr),
    .sel_n      (sel_n),
    .oe_n       (oe_n),
    .prog_n     (prog_n),
    .supply_sel (supply_sel),
    .busy       (busy),
    .done       (done),
    .reject     (reject)
);

// File: tb/sim_prom_scan.sv
// Directed bench for prom_scan: a memory model answering per supply level,
// a strobe-timing monitor, and one task per scenario.
module sim_prom_scan;

    localparam int DEPTH  = 16;
    localparam int DW     = 8;
    localparam int T_D    = 3;
    localparam int T_AVEL = 2;
    localparam int T_ELQV = 4;
    localparam int AW     = $clog2(DEPTH);
    localparam int BUSY_V = T_D + DEPTH * 2 * T_D + 1;
    localparam int BUSY_M = 2 * (T_D + DEPTH * (T_D + T_AVEL + T_ELQV)) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [DW-1:0] ref_q, dev_q;
    logic [AW-1:0] dev_addr, fail_addr;
    logic          sel_n, oe_n, prog_n, busy, done, reject;
    logic [1:0]    supply_sel, fail_level;

    logic [DW-1:0] gold  [DEPTH];
    logic [DW-1:0] m_nom [DEPTH];
    logic [DW-1:0] m_low [DEPTH];
    logic [DW-1:0] m_high[DEPTH];

    int n_chk = 0;
    int n_fail = 0;

    // Monitor state
    int busy_cyc, pulses, lo_len, lo_min, lo_max, gap, gap_min;
    int gap_at_high, first_high_addr, n_low, n_high, n_nom, done_cyc, prog_low;
    int addr_moves;
    logic [AW-1:0] pulse_addr;

    always #4 clk = ~clk;

    prom_scan #(.DEPTH(DEPTH), .DW(DW), .T_D(T_D), .T_AVEL(T_AVEL), .T_ELQV(T_ELQV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ref_q(ref_q), .dev_q(dev_q), .dev_addr(dev_addr), .sel_n(sel_n),
        .oe_n(oe_n), .prog_n(prog_n), .supply_sel(supply_sel), .busy(busy),
        .done(done), .reject(reject), .fail_addr(fail_addr), .fail_level(fail_level)
    );

    // Expected-data port and memory model, answering by supply level.
    always_comb begin
        ref_q = gold[dev_addr];
        if (sel_n || oe_n)          dev_q = '0;
        else if (supply_sel == 2'd1) dev_q = m_low[dev_addr];
        else if (supply_sel == 2'd2) dev_q = m_high[dev_addr];
        else                         dev_q = m_nom[dev_addr];
    end

    // Strobe-timing monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (busy) busy_cyc++;
        if (done) done_cyc++;
        if (busy && !prog_n) prog_low++;
        if (!sel_n) begin
            if (lo_len == 0) begin
                pulses++;
                pulse_addr = dev_addr;
                if (gap < gap_min) gap_min = gap;
                if (supply_sel == 2'd1) n_low++;
                else if (supply_sel == 2'd2) begin
                    if (n_high == 0) begin
                        gap_at_high = gap;
                        first_high_addr = int'(dev_addr);
                    end
                    n_high++;
                end else n_nom++;
            end else if (dev_addr != pulse_addr) addr_moves++;
            lo_len++;
        end else begin
            if (lo_len > 0) begin
                if (lo_len < lo_min) lo_min = lo_len;
                if (lo_len > lo_max) lo_max = lo_len;
                lo_len = 0;
                gap = 0;
            end
            if (busy) gap++;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic mon_clear();
        busy_cyc = 0; pulses = 0; lo_len = 0; lo_min = 1 << 30; lo_max = 0;
        gap = 0; gap_min = 1 << 30; gap_at_high = -1; first_high_addr = -1;
        n_low = 0; n_high = 0; n_nom = 0; done_cyc = 0; prog_low = 0; addr_moves = 0;
    endtask

    task automatic fill(input logic [DW-1:0] seed);
        for (int i = 0; i < DEPTH; i++) begin
            gold[i]   = DW'(i * 37) ^ seed;
            m_nom[i]  = gold[i];
            m_low[i]  = gold[i];
            m_high[i] = gold[i];
        end
    endtask

    // Pulse start for one cycle, optionally poke start mid-scan, wait for idle.
    task automatic run(input logic [1:0] m, input logic poke);
        mon_clear();
        @(negedge clk);
        mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            mode = 2'd2; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_eq("R1 busy", int'(busy), 0);
        chk_eq("R1 done", int'(done), 0);
        chk_eq("R1 reject", int'(reject), 0);
        chk(sel_n && oe_n && prog_n, "R1 strobes idle", int'({sel_n, oe_n, prog_n}), 7);
        chk_eq("R1 supply", int'(supply_sel), 0);
    endtask

    task automatic t_blank_pass();
        fill(8'hA5);
        for (int i = 0; i < DEPTH; i++) m_nom[i] = '0;
        run(2'd0, 1'b0);
        chk_eq("R3 blank pass reject", int'(reject), 0);
        chk_eq("R3 blank pulses", pulses, DEPTH);
        chk_eq("R4 blank sel low width", lo_max, T_D);
        chk_eq("R6 blank busy cycles", busy_cyc, BUSY_V);
        chk_eq("R8 blank done cycles", done_cyc, 1);
    endtask

    task automatic t_blank_fail();
        fill(8'h00);
        for (int i = 0; i < DEPTH; i++) m_nom[i] = '0;
        m_nom[9] = 8'h04;
        run(2'd0, 1'b0);
        chk_eq("R3 blank fault reject", int'(reject), 1);
        chk_eq("R7 blank fail addr", int'(fail_addr), 9);
        chk_eq("R7 blank fail level", int'(fail_level), 0);
        chk_eq("R7 blank stop pulses", pulses, 10);
        chk_eq("R8 blank fail done", done_cyc, 1);
    endtask

    task automatic t_verify_pass();
        fill(8'h3C);
        run(2'd1, 1'b1);
        chk_eq("R4 verify reject", int'(reject), 0);
        chk_eq("R4 verify nominal pulses", n_nom, DEPTH);
        chk_eq("R4 verify sel low min", lo_min, T_D);
        chk_eq("R4 verify sel low max", lo_max, T_D);
        chk_eq("R4 verify address setup", gap_min, T_D);
        chk_eq("R4 prog strobe low cycles", prog_low, 0);
        chk_eq("R2 mid-scan start busy", busy_cyc, BUSY_V);
        chk_eq("R2 mid-scan start no margin", n_low + n_high, 0);
        chk_eq("R9 verify addr moves", addr_moves, 0);
    endtask

    task automatic t_verify_fail();
        fill(8'h5A);
        m_nom[DEPTH-1] = gold[DEPTH-1] ^ 8'h80;
        run(2'd1, 1'b0);
        chk_eq("R7 verify reject", int'(reject), 1);
        chk_eq("R7 verify fail addr", int'(fail_addr), DEPTH - 1);
        chk_eq("R7 verify fail level", int'(fail_level), 0);
    endtask

    task automatic t_margin_pass();
        fill(8'hC3);
        for (int i = 0; i < DEPTH; i++) m_nom[i] = ~gold[i];
        run(2'd2, 1'b0);
        chk_eq("R5 margin reject", int'(reject), 0);
        chk_eq("R5 margin low pulses", n_low, DEPTH);
        chk_eq("R5 margin high pulses", n_high, DEPTH);
        chk_eq("R5 margin nominal pulses", n_nom, 0);
        chk_eq("R5 margin sel low width", lo_max, T_ELQV);
        chk_eq("R5 margin address setup", gap_min, T_D + T_AVEL);
        chk_eq("R6 level change gap", gap_at_high, 2 * T_D + T_AVEL);
        chk_eq("R6 margin busy cycles", busy_cyc, BUSY_M);
        chk_eq("R9 high sweep first addr", first_high_addr, 0);
        chk_eq("R8 margin done cycles", done_cyc, 1);
        chk_eq("R1 supply back to nominal", int'(supply_sel), 0);
    endtask

    task automatic t_margin_fail_high();
        fill(8'h11);
        m_high[5] = gold[5] ^ 8'h01;
        run(2'd2, 1'b0);
        chk_eq("R7 high fail reject", int'(reject), 1);
        chk_eq("R7 high fail addr", int'(fail_addr), 5);
        chk_eq("R7 high fail level", int'(fail_level), 2);
        chk_eq("R7 high fail pulses", pulses, DEPTH + 6);
    endtask

    task automatic t_margin_fail_low();
        fill(8'h77);
        m_low[0] = gold[0] ^ 8'h10;
        run(2'd2, 1'b0);
        chk_eq("R7 low fail reject", int'(reject), 1);
        chk_eq("R7 low fail addr", int'(fail_addr), 0);
        chk_eq("R7 low fail level", int'(fail_level), 1);
        chk_eq("R7 low fail pulses", pulses, 1);
    endtask

    task automatic t_reserved_mode();
        mon_clear();
        @(negedge clk);
        mode = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk_eq("R2 reserved busy cycles", busy_cyc, 0);
        chk_eq("R2 reserved oe_n", int'(oe_n), 1);
        chk_eq("R2 reserved reject kept", int'(reject), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        fill(8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_blank_pass();
        t_blank_fail();
        t_verify_pass();
        t_verify_fail();
        t_reserved_mode();
        t_margin_pass();
        t_margin_fail_high();
        t_margin_fail_low();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule